// File: doc/BRIEF.md
# Pipelined Table Sample Scaler

The block plays a fixed waveform table out to a parallel DAC at one sample per clock, at rates around 100 MHz. A pointer walks the table while the enable input is high. Each entry read from the table is multiplied by an unsigned scale coefficient, and the scaled value is driven to the converter bus together with a valid flag.

Three registers split the path into separate stages: the issued address, the registered table read, and the registered product. No combinational path runs from the address through both the table and the multiplier. The last register feeds the output pins with no gate after it, so it can be placed in the I/O cells. The latency is fixed at three cycles, and throughput stays at one sample per clock.

Top module: `rom_scale_pipe`

## Requirements
- R1: While `en` stays high, `dac_valid` stays high on every cycle after the initial latency, and each valid word comes from the table entry after the one used for the previous word.
- R2: The table holds 64 entries, and entry k equals (2731*k + 1000) mod 16384. After reset, entry 0 (value 1000) is the first one played.
- R3: `dac_data` equals floor(entry * coef / 16384). This is bits 27 down to 14 of the 28-bit unsigned product, so the coefficient is unsigned fixed point with full scale equal to 16384.
- R4: The entry addressed at the clock edge where `en` is sampled high appears on `dac_data` after the third edge from that one. `dac_valid` is a copy of `en` delayed by exactly three cycles.
- R5: `coef` is sampled at the output stage. The word that appears after an edge uses the `coef` value present at that edge, so a coefficient change shows on the very next output word.
- R6: After entry 63 the pointer returns to entry 0 and keeps stepping without a gap.
- R7: While `en` is low the pointer holds its position. When `en` returns high, playback resumes at the next unplayed entry.
- R8: A synchronous active-high `rst` clears `dac_data` to 0, `dac_valid` to 0 and the pointer to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Steps the table pointer and issues a sample each cycle it is high |
| coef | input | 14 | Unsigned scale coefficient, full scale 16384 |
| dac_data | output | 14 | Registered scaled sample to the DAC |
| dac_valid | output | 1 | High when dac_data carries a sample issued three cycles earlier |

## Verification
The pointer wrap from entry 63 to 0 and a drop of `en` can land on the same edge. The bench forces this by holding `en` high for exactly the number of cycles that brings the pointer to the last entry and then pulling it low. It then checks that the three samples already in flight still come out, with valid falling three cycles later. After `en` rises again, the first sample must be entry 0 and not a repeat of entry 63. A second collision, where the coefficient changes on the same cycle that valid first rises, is judged against a bench model that applies each cycle's coefficient to the word leaving the table stage.

// File: rtl/rom_scale_pipe.sv
module rom_scale_pipe #(
  parameter int DATA_W = 14,
  parameter int COEF_W = 14,
  parameter int ADDR_W = 6,
  parameter int STEP   = 2731,
  parameter int BASE   = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [COEF_W-1:0] coef,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_valid
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'((1 << ADDR_W) - 1);

  logic [ADDR_W-1:0] ptr, addr_q;
  logic [DATA_W-1:0] rom_q;
  logic              v_addr, v_rom;
  logic [PROD_W-1:0] prod;

  function automatic logic [DATA_W-1:0] entry(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'(STEP) + 32'(BASE);
    return t[DATA_W-1:0];
  endfunction

  assign prod = PROD_W'(rom_q) * PROD_W'(coef);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      addr_q <= '0;
      v_addr <= 1'b0;
    end else begin
      addr_q <= ptr;
      v_addr <= en;
      if (en) ptr <= (ptr == LAST) ? '0 : ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_q <= '0;
      v_rom <= 1'b0;
    end else begin
      rom_q <= entry(addr_q);
      v_rom <= v_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_data  <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_data  <= prod[PROD_W-1:COEF_W];
      dac_valid <= v_rom;
    end
  end
endmodule

module rom_scale_pipe_chk #(
  parameter int DATA_W = 14,
  parameter int COEF_W = 14,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [COEF_W-1:0] coef,
  input logic [ADDR_W-1:0] ptr,
  input logic [DATA_W-1:0] rom_q,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_valid
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'((1 << ADDR_W) - 1);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (dac_valid == $past(en, 3))); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + ADDR_W'(1)))); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ptr)); // R7
  AST_SCALE: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (dac_data == DATA_W'((PROD_W'($past(rom_q)) * PROD_W'($past(coef))) >> COEF_W))); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!dac_valid && dac_data == '0 && ptr == '0)); // R8
endmodule

bind rom_scale_pipe rom_scale_pipe_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .coef(coef), .ptr(ptr),
  .rom_q(rom_q), .dac_data(dac_data), .dac_valid(dac_valid)
);

// File: tb/test_rom_scale_pipe.sv
module test_rom_scale_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [13:0] coef = '0;
  logic [13:0] dac_data;
  logic        dac_valid;
  int checks = 0, failures = 0;
  bit done = 0;

  rom_scale_pipe i_rom_scale_pipe (
    .clk(clk), .rst(rst), .en(en), .coef(coef),
    .dac_data(dac_data), .dac_valid(dac_valid)
  );

  always #10 clk = ~clk;

  // segment: {en, coef[13:0], length[7:0]}
  localparam logic [22:0] SEGS [8] = '{
    {1'b1, 14'd8192,  8'd20}, {1'b1, 14'd16383, 8'd50},
    {1'b0, 14'd16383, 8'd5},  {1'b1, 14'd0,     8'd6},
    {1'b1, 14'd5000,  8'd3},  {1'b0, 14'd5000,  8'd2},
    {1'b1, 14'd1,     8'd70}, {1'b0, 14'd1,     8'd6}
  };

  int m_ptr, m_addr, m_rom, m_out;
  bit m_v0, m_v1, m_v2;

  function automatic int ent(int k);
    return (2731 * k + 1000) % 16384;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0; m_addr = 0; m_rom = 0; m_out = 0;
    m_v0 = 0; m_v1 = 0; m_v2 = 0;
  endtask

  task automatic step(input bit e, input int c, input string tag);
    en = e; coef = 14'(c);
    @(posedge clk);
    m_out = (m_rom * c) / 16384;
    m_v2 = m_v1;
    m_rom = ent(m_addr);
    m_v1 = m_v0;
    m_addr = m_ptr;
    m_v0 = e;
    if (e) m_ptr = (m_ptr == 63) ? 0 : m_ptr + 1;
    @(negedge clk);
    check({tag, " valid"}, int'(dac_valid), int'(m_v2));
    if (m_v2) check({tag, " data"}, int'(dac_data), m_out);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R8 reset valid", int'(dac_valid), 0);
    check("R8 reset data", int'(dac_data), 0);

    // R4 latency and R2 first entry, computed by hand: 1000*16383>>14 = 999
    step(1, 16383, "R4");
    check("R4 valid low after 1 edge", int'(dac_valid), 0);
    step(1, 16383, "R4");
    check("R4 valid low after 2 edges", int'(dac_valid), 0);
    step(1, 16383, "R4");
    check("R4 valid high after 3 edges", int'(dac_valid), 1);
    check("R2 first entry scaled", int'(dac_data), 999);

    // R5 coefficient change every cycle
    for (int i = 0; i < 8; i++) step(1, (i % 2) ? 3000 : 12000, "R5");

    // main stream: table of segments (R1, R3)
    do_reset();
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < int'(SEGS[s][7:0]); i++)
        step(SEGS[s][22], int'(SEGS[s][21:8]), "R1 R3");

    // R6 + R7: en drops on the edge that plays entry 63, resume must be 0
    do_reset();
    for (int i = 0; i < 64; i++) step(1, 16383, "R6");
    check("R6 pointer at wrap", m_ptr, 0);
    for (int i = 0; i < 5; i++) step(0, 16383, "R7");
    check("R7 drained", int'(dac_valid), 0);
    for (int i = 0; i < 3; i++) step(1, 16383, "R7");
    check("R6 resume entry 0", int'(dac_data), 999);
    for (int i = 0; i < 4; i++) step(1, 16383, "R6");

    // R8 reset mid-stream restarts at entry 0
    do_reset();
    check("R8 mid reset valid", int'(dac_valid), 0);
    for (int i = 0; i < 3; i++) step(1, 8192, "R8");
    check("R8 restart entry 0", int'(dac_data), 500);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule